// File: doc/BRIEF.md
# Two-Layer Video Layer Blender

This block merges two pixel streams that run in lockstep, a background layer and an overlay layer, into a single output stream. Each pixel carries red, green, blue and alpha components of `CW` bits. A mode input selects how the two layers are combined.

In blend mode, the overlay alpha weights the overlay pixel against the background pixel. In transparency mode, no arithmetic is done. One layer is the priority layer and its pixel is passed through whole. If the priority pixel is fully transparent, the other layer's pixel is passed through instead. A second control input swaps which layer holds priority.

Both inputs use valid/ready handshakes and are joined, so that one background pixel and one overlay pixel are always consumed together. The result sits in a single output register that takes backpressure.

Top module: `layer_mixer`

## Requirements
- R1: After reset, `out_valid` is 0.
- R2: An input is accepted only when both `bg_valid` and `ov_valid` are high and the output register is empty or being drained. `bg_ready` is never high while `ov_valid` is low, and `ov_ready` is never high while `bg_valid` is low, so both pixels are taken in the same cycle.
- R3: A pair of pixels accepted at a clock edge shows up on `out_pix`, with `out_valid` high, right after that edge. While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_pix` holds its value.
- R4: Pixels are packed as {alpha, red, green, blue}, with alpha in the top `CW` bits and blue in the bottom `CW` bits. In blend mode (`mode_transp`=0), each colour component is out = (O*a + B*(M-a) + (M>>1)) / M, rounded down. Here O is the overlay component, B is the background component, a is the overlay alpha and M = 2^CW-1.
- R5: In blend mode, the output alpha is (M*a + Ab*(M-a) + (M>>1)) / M, where Ab is the background alpha.
- R6: In blend mode, an overlay alpha of M gives exactly the overlay pixel, and an overlay alpha of 0 gives exactly the background pixel.
- R7: In transparency mode (`mode_transp`=1) with `prio_bg`=0, the output is the overlay pixel unless the overlay alpha is 0. In that case the output is the background pixel.
- R8: In transparency mode with `prio_bg`=1, the output is the background pixel unless the background alpha is 0. In that case the output is the overlay pixel.
- R9: `mode_transp` and `prio_bg` are sampled only in the cycle the inputs are accepted. Changing them while an output is held has no effect on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_transp | input | 1 | 0 = alpha blend, 1 = transparency |
| prio_bg | input | 1 | 1 = background is the priority layer in transparency mode |
| bg_valid | input | 1 | Background pixel valid |
| bg_ready | output | 1 | Background pixel accepted |
| bg_pix | input | 4*CW | Background pixel {a,r,g,b} |
| ov_valid | input | 1 | Overlay pixel valid |
| ov_ready | output | 1 | Overlay pixel accepted |
| ov_pix | input | 4*CW | Overlay pixel {a,r,g,b} |
| out_valid | output | 1 | Output pixel valid |
| out_ready | input | 1 | Downstream accepts output |
| out_pix | output | 4*CW | Merged pixel {a,r,g,b} |

## Verification
The bench builds the block with the default `CW` = 8, so M = 255. At that width the rounding term and the division by 255 can be checked against hand-computable values. The width also puts both extreme alphas, 0 and 255, in reach, where blending must return one layer untouched. Directed scenarios cover both priority settings, with a zero-alpha and a non-zero-alpha priority pixel. They also cover one-sided valid inputs and a stalled output whose control inputs change while it waits.

// File: rtl/layer_mixer.sv
module layer_mixer #(
  parameter int CW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            mode_transp,
  input  logic            prio_bg,
  input  logic            bg_valid,
  output logic            bg_ready,
  input  logic [4*CW-1:0] bg_pix,
  input  logic            ov_valid,
  output logic            ov_ready,
  input  logic [4*CW-1:0] ov_pix,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [4*CW-1:0] out_pix
);
  localparam int PW = 4 * CW;
  localparam int W2 = 2 * CW + 1;
  localparam logic [CW-1:0] FULL = '1;

  logic          space, take;
  logic [CW-1:0] ova, bga;
  logic [PW-1:0] mix, pick;

  assign space    = !out_valid || out_ready;
  assign bg_ready = ov_valid && space;
  assign ov_ready = bg_valid && space;
  assign take     = bg_valid && ov_valid && space;

  assign ova = ov_pix[3*CW +: CW];
  assign bga = bg_pix[3*CW +: CW];

  for (genvar i = 0; i < 4; i++) begin : g_ch
    logic [W2-1:0] fg, bk, sum;
    assign fg  = (i == 3) ? W2'(FULL) : W2'(ov_pix[i*CW +: CW]);
    assign bk  = W2'(bg_pix[i*CW +: CW]);
    assign sum = fg * W2'(ova) + bk * W2'(FULL - ova) + W2'(FULL >> 1);
    assign mix[i*CW +: CW] = CW'(sum / W2'(FULL));
  end

  assign pick = prio_bg ? ((bga != '0) ? bg_pix : ov_pix)
                        : ((ova != '0) ? ov_pix : bg_pix);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_pix   <= '0;
    end else if (take) begin
      out_valid <= 1'b1;
      out_pix   <= mode_transp ? pick : mix;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/mixer_checks.sv
module mixer_checks #(
  parameter int CW = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            mode_transp,
  input logic            prio_bg,
  input logic            bg_valid,
  input logic            bg_ready,
  input logic [4*CW-1:0] bg_pix,
  input logic            ov_valid,
  input logic            ov_ready,
  input logic [4*CW-1:0] ov_pix,
  input logic            out_valid,
  input logic            out_ready,
  input logic [4*CW-1:0] out_pix
);
  localparam logic [CW-1:0] FULL = '1;
  logic acc;
  assign acc = bg_valid && bg_ready;

  assert_idle_after_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !out_valid);
  assert_join_bg_R2: assert property (@(posedge clk) disable iff (!rst_n)
    bg_ready |-> ov_valid);
  assert_join_ov_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ov_ready |-> bg_valid);
  assert_latency_R3: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> out_valid);
  assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_pix)));
  assert_opaque_ov_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !mode_transp && ov_pix[3*CW +: CW] == FULL) |=> out_pix == $past(ov_pix));
  assert_clear_ov_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !mode_transp && ov_pix[3*CW +: CW] == '0) |=> out_pix == $past(bg_pix));
  assert_prio_ov_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && mode_transp && !prio_bg && ov_pix[3*CW +: CW] != '0) |=> out_pix == $past(ov_pix));
  assert_prio_bg_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && mode_transp && prio_bg && bg_pix[3*CW +: CW] != '0) |=> out_pix == $past(bg_pix));
endmodule

bind layer_mixer mixer_checks #(.CW(CW)) u_chk (.*);

// File: tb/sim_layer_mixer.sv
module sim_layer_mixer;
  localparam int CW = 8;
  localparam int PW = 4 * CW;

  logic clk = 0, rst_n = 0, mode_transp = 0, prio_bg = 0;
  logic bg_valid = 0, ov_valid = 0, out_ready = 1;
  logic [PW-1:0] bg_pix = '0, ov_pix = '0;
  logic bg_ready, ov_ready, out_valid;
  logic [PW-1:0] out_pix;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  layer_mixer #(.CW(CW)) u0 (.*);

  function automatic logic [7:0] bl(input int o, input int b, input int a);
    return 8'((o * a + b * (255 - a) + 127) / 255);
  endfunction

  function automatic logic [PW-1:0] ref_mix(input logic [PW-1:0] b, input logic [PW-1:0] o);
    int a;
    a = int'(o[31:24]);
    return {bl(255, int'(b[31:24]), a), bl(int'(o[23:16]), int'(b[23:16]), a),
            bl(int'(o[15:8]), int'(b[15:8]), a), bl(int'(o[7:0]), int'(b[7:0]), a)};
  endfunction

  task automatic chk(input string req, input logic [PW-1:0] act, input logic [PW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic send(input logic [PW-1:0] b, input logic [PW-1:0] o,
                      input logic m, input logic p, input string req, input logic [PW-1:0] exp);
    @(negedge clk);
    bg_pix = b; ov_pix = o; mode_transp = m; prio_bg = p;
    bg_valid = 1; ov_valid = 1; out_ready = 1;
    @(negedge clk);
    bg_valid = 0; ov_valid = 0;
    chk({req, " valid"}, PW'(out_valid), PW'(1));
    chk(req, out_pix, exp);
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk("R1 out_valid after reset", PW'(out_valid), PW'(0));
  endtask

  task automatic t_blend;
    logic [PW-1:0] b, o;
    b = 32'hC8_64_10_F0; o = 32'h80_C8_FF_00;
    send(b, o, 0, 0, "R4 R5 blend mid", ref_mix(b, o));
    b = 32'h40_00_FF_7F; o = 32'h01_FF_00_80;
    send(b, o, 0, 0, "R4 R5 blend low alpha", ref_mix(b, o));
    b = 32'h00_11_22_33; o = 32'hFE_AA_55_01;
    send(b, o, 0, 1, "R4 R5 blend high alpha, prio ignored", ref_mix(b, o));
    send(32'h00_00_00_00, 32'h80_FF_FF_FF, 0, 0, "R5 alpha over clear bg", 32'h80_80_80_80);
  endtask

  task automatic t_extremes;
    send(32'h33_12_34_56, 32'hFF_9A_BC_DE, 0, 0, "R6 alpha full", 32'hFF_9A_BC_DE);
    send(32'h33_12_34_56, 32'h00_9A_BC_DE, 0, 0, "R6 alpha zero", 32'h33_12_34_56);
  endtask

  task automatic t_transp;
    send(32'hFF_01_02_03, 32'h01_A0_B0_C0, 1, 0, "R7 overlay shown", 32'h01_A0_B0_C0);
    send(32'hFF_01_02_03, 32'h00_A0_B0_C0, 1, 0, "R7 overlay clear", 32'hFF_01_02_03);
    send(32'h05_01_02_03, 32'hFF_A0_B0_C0, 1, 1, "R8 background shown", 32'h05_01_02_03);
    send(32'h00_01_02_03, 32'h7F_A0_B0_C0, 1, 1, "R8 background clear", 32'h7F_A0_B0_C0);
  endtask

  task automatic t_join;
    @(negedge clk);
    bg_valid = 1; ov_valid = 0; bg_pix = 32'hFF_FF_FF_FF;
    #1;
    chk("R2 bg_ready without ov_valid", PW'(bg_ready), PW'(0));
    @(negedge clk);
    chk("R2 no output from one side", PW'(out_valid), PW'(0));
    bg_valid = 0; ov_valid = 1;
    #1;
    chk("R2 ov_ready without bg_valid", PW'(ov_ready), PW'(0));
    @(negedge clk);
    chk("R2 no output from other side", PW'(out_valid), PW'(0));
    ov_valid = 0;
  endtask

  task automatic t_stall;
    @(negedge clk);
    out_ready = 0;
    bg_pix = 32'h10_20_30_40; ov_pix = 32'h00_50_60_70;
    mode_transp = 1; prio_bg = 0; bg_valid = 1; ov_valid = 1;
    @(negedge clk);
    chk("R3 first held", out_pix, 32'h10_20_30_40);
    bg_pix = 32'hAA_AA_AA_AA; ov_pix = 32'hBB_BB_BB_BB;
    mode_transp = 0; prio_bg = 1;
    for (int k = 0; k < 3; k++) begin
      #1;
      chk("R2 no accept while full", PW'(bg_ready), PW'(0));
      @(negedge clk);
      chk("R3 R9 hold under stall", out_pix, 32'h10_20_30_40);
      chk("R3 valid under stall", PW'(out_valid), PW'(1));
    end
    out_ready = 1;
    @(negedge clk);
    bg_valid = 0; ov_valid = 0;
    chk("R3 second after drain", out_pix, ref_mix(32'hAA_AA_AA_AA, 32'hBB_BB_BB_BB));
    @(negedge clk);
    chk("R3 empty after drain", PW'(out_valid), PW'(0));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_blend();
    t_extremes();
    t_transp();
    t_join();
    t_stall();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule